// File: doc/BRIEF.md
# Variable-Rate Slot Request Generator

This block sits on the codec side of a frame-based serial audio link whose frames arrive at a fixed 48 kHz. Once per frame, on a frame-start strobe, it decides which playback (DAC) slots the controller must fill in the following output frame. It signals each decision through an active-low request flag. It also decides whether the capture (ADC) slot of the next input frame carries a fresh sample, which it marks with a tag-valid bit.

The block holds a small register set: an extended control word with a variable-rate enable and an SPDIF enable, and one sample-rate register each for the DAC side and the ADC side. With variable rate off, both rates are pinned at 48000 and every frame requests and carries data. With variable rate on, a phase accumulator for each channel adds the programmed rate every frame. A request fires whenever the sum reaches 48000, so the request rate follows the programmed sample rate. A full playback FIFO defers a due request. When a requested slot arrives untagged, the block records an underrun instead of writing the FIFO.

Top module: `slot_req_gen`

## Requirements
- R1: After reset the variable-rate enable and SPDIF enable are 0, both rate registers read 48000, every slot_req_n is 1 (inactive), in_tag_valid, fifo_wr, adc_strobe and underrun are 0.
- R2: Writing the control register (address 2Ah) with bit 0 clear forces both rate registers to 48000 on the same clock edge. A rate register write made while variable rate is off leaves the register at 48000.
- R3: With variable rate on, a write to the DAC rate register (2Ch) or ADC rate register (32h) stores the value clamped to the range 8000 to 48000.
- R4: Reading 2Ah returns variable-rate enable on bit 0, SPDIF enable on bit 2, and the input spdif_cfg_ok on bit 10 (a write to bit 10 has no effect). All other bits read 0. Reads of 2Ch and 32h return the rates. Any other address reads 0. reg_rdata is combinational from reg_addr.
- R5: With variable rate off, every frame_start drives all slot_req_n low and in_tag_valid high, whatever the FIFO levels are.
- R6: With variable rate on, each DAC channel adds the DAC rate to its accumulator at frame_start. If the sum is at least 48000, the channel drives its slot_req_n low and keeps the sum minus 48000. Otherwise the flag goes high and the sum is kept.
- R7: A DAC channel whose fifo_level is at least FIFO_DEPTH, with variable rate on and a request due, does not request and keeps its accumulator unchanged.
- R8: At frame_start, a channel that requested in the previous frame pulses fifo_wr in the next cycle if its out_tag bit is 1. If the bit is 0, the channel sets its underrun bit, which stays set until reset. Tags of channels that did not request are ignored.
- R9: The ADC side runs the same accumulator without FIFO gating and drives in_tag_valid. adc_strobe pulses in the cycle after frame_start when in_tag_valid is 1.
- R10: slot_req_n and in_tag_valid change only on the clock edge where frame_start is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| spdif_cfg_ok | input | 1 | SPDIF configuration-valid status from the encoder |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| out_tag | input | NUM_DAC | Tag bits of the incoming output frame's DAC slots |
| fifo_level | input | NUM_DAC*LVL_W | Fill level of each playback FIFO |
| slot_req_n | output | NUM_DAC | Active-low slot request flags |
| fifo_wr | output | NUM_DAC | Playback FIFO write pulse for each channel |
| underrun | output | NUM_DAC | Sticky missing-sample flags |
| in_tag_valid | output | 1 | Tag bit of the ADC input slot |
| adc_strobe | output | 1 | Pulse to take a new ADC sample |

## Verification
The pacing is driven at rates of 48000, 8000, 24000 and 44100. Each rate gives a distinct request period, so a wrong threshold, a missing subtract or a one-frame shift shows up as a different flag pattern. Frames with a full FIFO are run in both enable states. They separate the rule that gating applies only under variable rate, and they show that a held-off request keeps its accumulator. Tag patterns on requested and unrequested slots separate a write, an underrun and an ignored tag. Out-of-range and disabled-mode rate writes exercise clamping and the 48000 override.

// File: rtl/vrsr_pkg.sv
package vrsr_pkg;

    localparam int RATE_W     = 16;
    localparam int ADDR_W     = 7;
    localparam int FRAME_RATE = 48000;
    localparam int RATE_MIN   = 8000;

    localparam logic [ADDR_W-1:0] ADDR_EXT_CTRL = 7'h2A;
    localparam logic [ADDR_W-1:0] ADDR_DAC_RATE = 7'h2C;
    localparam logic [ADDR_W-1:0] ADDR_ADC_RATE = 7'h32;

    localparam int BIT_VRA   = 0;
    localparam int BIT_SPDIF = 2;
    localparam int BIT_CFGOK = 10;

    typedef struct packed {
        logic vra;
        logic spdif_en;
    } ext_ctrl_t;

    typedef struct packed {
        logic [RATE_W-1:0] dac;
        logic [RATE_W-1:0] adc;
    } rate_pair_t;

    typedef enum logic [1:0] {
        ACC_STEP,
        ACC_FIRE,
        ACC_HOLD,
        ACC_FIXED
    } acc_evt_e;

    function automatic logic [RATE_W-1:0] clamp_rate(input logic [RATE_W-1:0] v);
        if (v < RATE_W'(RATE_MIN))
            return RATE_W'(RATE_MIN);
        else if (v > RATE_W'(FRAME_RATE))
            return RATE_W'(FRAME_RATE);
        else
            return v;
    endfunction

endpackage

// File: rtl/vrsr_regs.sv
module vrsr_regs
    import vrsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RATE_W-1:0] wdata,
    input  logic              cfg_ok,
    output logic [RATE_W-1:0] rdata,
    output ext_ctrl_t         ctrl,
    output rate_pair_t        rates
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.vra      <= 1'b0;
            ctrl.spdif_en <= 1'b0;
            rates.dac     <= RATE_W'(FRAME_RATE);
            rates.adc     <= RATE_W'(FRAME_RATE);
        end else if (wr) begin
            unique case (addr)
                ADDR_EXT_CTRL: begin
                    ctrl.vra      <= wdata[BIT_VRA];
                    ctrl.spdif_en <= wdata[BIT_SPDIF];
                    if (!wdata[BIT_VRA]) begin
                        rates.dac <= RATE_W'(FRAME_RATE);
                        rates.adc <= RATE_W'(FRAME_RATE);
                    end
                end
                ADDR_DAC_RATE: if (ctrl.vra) rates.dac <= clamp_rate(wdata);
                ADDR_ADC_RATE: if (ctrl.vra) rates.adc <= clamp_rate(wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_EXT_CTRL: begin
                rdata[BIT_VRA]   = ctrl.vra;
                rdata[BIT_SPDIF] = ctrl.spdif_en;
                rdata[BIT_CFGOK] = cfg_ok;
            end
            ADDR_DAC_RATE: rdata = rates.dac;
            ADDR_ADC_RATE: rdata = rates.adc;
            default:       rdata = '0;
        endcase
    end

endmodule

// File: rtl/vrsr_accum.sv
module vrsr_accum
    import vrsr_pkg::*;
#(
    parameter int ACC_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              vra,
    input  logic [RATE_W-1:0] rate,
    input  logic              hold,
    output logic              fire
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    acc_evt_e         evt;

    assign sum = acc_q + ACC_W'(rate);

    always_comb begin
        if (!vra)
            evt = ACC_FIXED;
        else if (sum >= ACC_W'(FRAME_RATE))
            evt = hold ? ACC_HOLD : ACC_FIRE;
        else
            evt = ACC_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            fire  <= 1'b0;
        end else if (step) begin
            unique case (evt)
                ACC_FIXED: begin acc_q <= '0;                        fire <= 1'b1; end
                ACC_FIRE:  begin acc_q <= sum - ACC_W'(FRAME_RATE);  fire <= 1'b1; end
                ACC_HOLD:  begin acc_q <= acc_q;                     fire <= 1'b0; end
                default:   begin acc_q <= sum;                       fire <= 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/slot_req_gen.sv
module slot_req_gen
    import vrsr_pkg::*;
#(
    parameter int NUM_DAC    = 2,
    parameter int FIFO_DEPTH = 8,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [6:0]               reg_addr,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              reg_rdata,
    input  logic                     spdif_cfg_ok,
    input  logic                     frame_start,
    input  logic [NUM_DAC-1:0]       out_tag,
    input  logic [NUM_DAC*LVL_W-1:0] fifo_level,
    output logic [NUM_DAC-1:0]       slot_req_n,
    output logic [NUM_DAC-1:0]       fifo_wr,
    output logic [NUM_DAC-1:0]       underrun,
    output logic                     in_tag_valid,
    output logic                     adc_strobe
);

    localparam int ACC_W = $clog2(2 * FRAME_RATE + 1);

    ext_ctrl_t          ctrl;
    rate_pair_t         rates;
    logic               vra_on;
    logic [RATE_W-1:0]  dac_rate;
    logic [RATE_W-1:0]  adc_rate;
    logic [NUM_DAC-1:0] dac_fire;
    logic [NUM_DAC-1:0] fifo_full;
    logic               adc_fire;
    logic               fs_d;

    assign vra_on   = ctrl.vra;
    assign dac_rate = rates.dac;
    assign adc_rate = rates.adc;

    vrsr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .cfg_ok (spdif_cfg_ok),
        .rdata  (reg_rdata),
        .ctrl   (ctrl),
        .rates  (rates)
    );

    for (genvar ch = 0; ch < NUM_DAC; ch++) begin : g_dac
        assign fifo_full[ch] = fifo_level[ch*LVL_W +: LVL_W] >= LVL_W'(FIFO_DEPTH);

        vrsr_accum #(.ACC_W(ACC_W)) u_acc (
            .clk  (clk),
            .rst  (rst),
            .step (frame_start),
            .vra  (vra_on),
            .rate (dac_rate),
            .hold (fifo_full[ch]),
            .fire (dac_fire[ch])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                fifo_wr[ch]  <= 1'b0;
                underrun[ch] <= 1'b0;
            end else begin
                fifo_wr[ch] <= frame_start & dac_fire[ch] & out_tag[ch];
                if (frame_start && dac_fire[ch] && !out_tag[ch])
                    underrun[ch] <= 1'b1;
            end
        end
    end

    vrsr_accum #(.ACC_W(ACC_W)) u_adc_acc (
        .clk  (clk),
        .rst  (rst),
        .step (frame_start),
        .vra  (vra_on),
        .rate (adc_rate),
        .hold (1'b0),
        .fire (adc_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) fs_d <= 1'b0;
        else     fs_d <= frame_start;
    end

    assign slot_req_n   = ~dac_fire;
    assign in_tag_valid = adc_fire;
    assign adc_strobe   = fs_d & adc_fire;

endmodule

// File: rtl/slot_req_gen_chk.sv
module slot_req_gen_chk #(
    parameter int NUM_DAC = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic               vra_on,
    input logic [15:0]        dac_rate,
    input logic [15:0]        adc_rate,
    input logic [NUM_DAC-1:0] slot_req_n,
    input logic [NUM_DAC-1:0] fifo_wr,
    input logic [NUM_DAC-1:0] underrun,
    input logic               in_tag_valid,
    input logic               adc_strobe
);

    // R2: disabled variable rate pins both rates at 48000
    p_rates_pinned_r2: assert property (@(posedge clk) disable iff (rst)
        !vra_on |-> (dac_rate == 16'd48000 && adc_rate == 16'd48000));

    // R3: stored rates stay inside the legal range
    p_rate_range_r3: assert property (@(posedge clk) disable iff (rst)
        dac_rate >= 16'd8000 && dac_rate <= 16'd48000 &&
        adc_rate >= 16'd8000 && adc_rate <= 16'd48000);

    // R5: a frame with variable rate off requests every slot
    p_all_req_r5: assert property (@(posedge clk) disable iff (rst)
        frame_start && !vra_on |=> (slot_req_n == '0 && in_tag_valid));

    // R8: FIFO writes only follow a frame start
    p_wr_after_frame_r8: assert property (@(posedge clk) disable iff (rst)
        (|fifo_wr) |-> $past(frame_start));

    // R8: underrun bits never clear
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((underrun & $past(underrun)) == $past(underrun)));

    // R9: a new ADC sample is only taken with a valid tag
    p_adc_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        adc_strobe |-> in_tag_valid);

    // R10: flags hold between frames
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(slot_req_n) && $stable(in_tag_valid)));

endmodule

bind slot_req_gen slot_req_gen_chk #(.NUM_DAC(NUM_DAC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .vra_on       (vra_on),
    .dac_rate     (dac_rate),
    .adc_rate     (adc_rate),
    .slot_req_n   (slot_req_n),
    .fifo_wr      (fifo_wr),
    .underrun     (underrun),
    .in_tag_valid (in_tag_valid),
    .adc_strobe   (adc_strobe)
);

// File: tb/sim_slot_req_gen.sv
`timescale 1ns/1ps
module sim_slot_req_gen;

    localparam int ND = 2;
    localparam int DEPTH = 8;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [6:0]    reg_addr = 7'h2A;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          spdif_cfg_ok = 1'b0;
    logic          frame_start = 1'b0;
    logic [ND-1:0] out_tag = '0;
    logic [ND*LW-1:0] fifo_level = '0;
    logic [ND-1:0] slot_req_n, fifo_wr, underrun;
    logic          in_tag_valid, adc_strobe;

    int checks = 0;
    int fails = 0;
    bit started = 0;

    always #4 clk = ~clk;

    slot_req_gen #(.NUM_DAC(ND), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spdif_cfg_ok(spdif_cfg_ok),
        .frame_start(frame_start), .out_tag(out_tag), .fifo_level(fifo_level),
        .slot_req_n(slot_req_n), .fifo_wr(fifo_wr), .underrun(underrun),
        .in_tag_valid(in_tag_valid), .adc_strobe(adc_strobe)
    );

    // behavioural reference
    int m_vra, m_spd, m_dac, m_adc;
    int m_acc[ND];
    int m_fire[ND];
    int m_fw[ND];
    int m_und[ND];
    int m_aacc, m_afire, m_fsd;

    function automatic int clampv(int v);
        if (v < 8000) return 8000;
        if (v > 48000) return 48000;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_vra = 0; m_spd = 0; m_dac = 48000; m_adc = 48000;
            m_aacc = 0; m_afire = 0; m_fsd = 0;
            for (int c = 0; c < ND; c++) begin
                m_acc[c] = 0; m_fire[c] = 0; m_fw[c] = 0; m_und[c] = 0;
            end
        end else begin
            m_fsd = frame_start;
            if (frame_start) begin
                for (int c = 0; c < ND; c++) begin
                    int s;
                    bit full;
                    m_fw[c] = (m_fire[c] != 0 && out_tag[c]) ? 1 : 0;
                    if (m_fire[c] != 0 && !out_tag[c]) m_und[c] = 1;
                    full = (int'(fifo_level[c*LW +: LW]) >= DEPTH);
                    if (m_vra == 0) begin m_acc[c] = 0; m_fire[c] = 1; end
                    else begin
                        s = m_acc[c] + m_dac;
                        if (s >= 48000) begin
                            if (full) m_fire[c] = 0;
                            else begin m_fire[c] = 1; m_acc[c] = s - 48000; end
                        end else begin m_fire[c] = 0; m_acc[c] = s; end
                    end
                end
                if (m_vra == 0) begin m_aacc = 0; m_afire = 1; end
                else if (m_aacc + m_adc >= 48000) begin m_afire = 1; m_aacc = m_aacc + m_adc - 48000; end
                else begin m_afire = 0; m_aacc = m_aacc + m_adc; end
            end else begin
                for (int c = 0; c < ND; c++) m_fw[c] = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    7'h2A: begin
                        m_vra = reg_wdata[0]; m_spd = reg_wdata[2];
                        if (!reg_wdata[0]) begin m_dac = 48000; m_adc = 48000; end
                    end
                    7'h2C: if (m_vra != 0) m_dac = clampv(int'(reg_wdata));
                    7'h32: if (m_vra != 0) m_adc = clampv(int'(reg_wdata));
                    default: ;
                endcase
            end
            started = 1;
        end
    end

    function automatic int exp_rdata();
        case (reg_addr)
            7'h2A: return m_vra | (m_spd << 2) | (int'(spdif_cfg_ok) << 10);
            7'h2C: return m_dac;
            7'h32: return m_adc;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the clock edge
    always @(negedge clk) begin
        if (started || !rst) begin
            for (int c = 0; c < ND; c++) begin
                chk("R1 R5 R6 R7 R10 slot_req_n", int'(slot_req_n[c]), m_fire[c] != 0 ? 0 : 1);
                chk("R8 fifo_wr", int'(fifo_wr[c]), m_fw[c]);
                chk("R8 underrun", int'(underrun[c]), m_und[c]);
            end
            chk("R9 in_tag_valid", int'(in_tag_valid), m_afire);
            chk("R9 adc_strobe", int'(adc_strobe), (m_fsd != 0 && m_afire != 0) ? 1 : 0);
            chk("R2 R3 R4 reg_rdata", int'(reg_rdata), exp_rdata());
        end
    end

    int rd_idx = 0;
    logic [6:0] rd_addrs [5] = '{7'h2A, 7'h2C, 7'h32, 7'h00, 7'h7F};

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic frame(input logic [ND-1:0] tag, input int l0, input int l1);
        frame_start = 1'b1; out_tag = tag;
        fifo_level = {LW'(l1), LW'(l0)};
        tick();
        frame_start = 1'b0; out_tag = ~tag;
        for (int k = 0; k < 3; k++) begin
            reg_addr = rd_addrs[rd_idx % 5];
            rd_idx++;
            tick();
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 R4: reset state and reads of every address
        for (int k = 0; k < 5; k++) begin reg_addr = rd_addrs[k]; tick(); end
        spdif_cfg_ok = 1'b1;
        tick();
        // R5: variable rate off, FIFOs full, requests every frame
        // R8: first frame's tags ignored since nothing was requested
        frame(2'b00, 8, 8);
        frame(2'b11, 8, 8);
        frame(2'b11, 8, 8);
        frame(2'b10, 0, 0);          // R8 underrun on channel 0
        // R2: rate write ignored while disabled
        wr_reg(7'h2C, 16'd8000);
        wr_reg(7'h32, 16'd11025);
        // R4: bit 10 write has no effect; enable variable rate and SPDIF
        wr_reg(7'h2A, 16'h0405);
        // R3: clamping
        wr_reg(7'h2C, 16'd5000);
        wr_reg(7'h32, 16'd60000);
        wr_reg(7'h2C, 16'd8000);
        wr_reg(7'h32, 16'd44100);
        spdif_cfg_ok = 1'b0;
        // R6 R9: pacing at 8000 and 44100
        for (int f = 0; f < 14; f++) frame(2'b11, 0, 3);
        // R6 R7: 24000 with channel 1 full, then draining
        wr_reg(7'h2C, 16'd24000);
        for (int f = 0; f < 4; f++) frame(2'b11, 7, 8);
        for (int f = 0; f < 4; f++) frame(2'b11, 2, 3);
        // R8: missing tag on channel 1 under variable rate
        wr_reg(7'h2C, 16'd48000);
        frame(2'b11, 0, 0);
        frame(2'b01, 0, 0);
        frame(2'b11, 0, 0);
        // R2: disabling restores 48000
        wr_reg(7'h2A, 16'h0004);
        for (int f = 0; f < 3; f++) frame(2'b11, 8, 8);
        for (int k = 0; k < 5; k++) begin reg_addr = rd_addrs[k]; tick(); end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule